// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses the direction of conditional branches. An 8-bit global history register records the predicted directions of recent branches. It indexes a table of 256 two-bit saturating counters. When the fetch stage asks for a prediction, the block returns a taken/not-taken bit and the history value that produced it. That value travels down the pipeline with the branch.

The history is updated speculatively with each predicted direction, so that a younger branch can predict before an older one resolves. When a branch resolves, the pipeline returns its outcome, its predicted direction and its carried history:

- The counter selected by the carried history is trained with the outcome.
- On a wrong guess, the history register is rebuilt from the carried history plus the real outcome, and a flush request is raised in the same cycle.

Top module: `gh_dir_predictor`

## Requirements
- R1: While rst_ni is low and after its release, the history is 0 and every counter holds weakly not-taken (binary 01), so an untrained entry predicts not-taken (0). flush_o is low.
- R2: pred_taken_o is bit 1 (the MSB) of the counter indexed by the current history. pred_hist_o shows the current history.
- R3: On a clock edge with pred_req_i high and no misprediction, the history becomes {history[6:0], pred_taken_o}.
- R4: On a clock edge with pred_req_i low and no misprediction, the history keeps its value.
- R5: On a clock edge with res_valid_i high, the counter at index res_hist_i changes by one step: up if res_taken_i is 1, down if it is 0. It saturates at 3 (binary 11) and at 0 (binary 00).
- R6: flush_o is high exactly when res_valid_i is high and res_taken_i differs from res_pred_i, in the same cycle.
- R7: On a misprediction the history becomes {res_hist_i[6:0], res_taken_i}. This wins over a prediction in the same cycle, whose shift is dropped.
- R8: When a prediction and a counter update target the same entry in one cycle, pred_taken_o shows the counter value from before the update.
- R9: When res_valid_i is low, the other res_* inputs change neither the table, the history nor flush_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_req_i | input | 1 | A branch asks for a prediction this cycle |
| pred_taken_o | output | 1 | Predicted direction, 1 means taken |
| pred_hist_o | output | HIST_W | History used for this prediction, carried with the branch |
| res_valid_i | input | 1 | A branch resolves this cycle |
| res_taken_i | input | 1 | Real outcome of the resolving branch |
| res_pred_i | input | 1 | Direction that was predicted for the resolving branch |
| res_hist_i | input | HIST_W | History carried back with the resolving branch |
| flush_o | output | 1 | Misprediction: flush younger work |

## Verification
The bench builds the block with its default HIST_W of 8. This gives the full 256-entry table, so random resolves spread across many counters and reach both saturation ends.

Because the history is only 8 bits wide, a short run of mispredict restores can place the history at any chosen index. This makes a same-entry read and update in one cycle easy to set up on purpose. Random traffic then mixes concurrent predictions, restores and resolves of stale histories taken from a queue of earlier predictions.

// File: rtl/gh_dir_pkg.sv
package gh_dir_pkg;
  localparam int unsigned CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_INIT = ctr_t'(1);  // weakly not-taken
  localparam ctr_t CTR_MAX  = '1;

  function automatic ctr_t ctr_step(ctr_t c, logic up);
    if (up) return (c == CTR_MAX) ? c : c + ctr_t'(1);
    else    return (c == '0)      ? c : c - ctr_t'(1);
  endfunction
endpackage

// File: rtl/gh_dir_history.sv
module gh_dir_history #(
  parameter int unsigned HIST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              shift_bit_i,
  input  logic              restore_i,
  input  logic [HIST_W-1:0] restore_val_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hist_q <= '0;
    else if (restore_i) hist_q <= restore_val_i;  // restore wins over shift
    else if (shift_i)   hist_q <= {hist_q[HIST_W-2:0], shift_bit_i};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/gh_dir_table.sv
module gh_dir_table
  import gh_dir_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_up_i
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  ctr_t ctr_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENTRIES; e++) ctr_q[e] <= CTR_INIT;
    end else if (wr_en_i) begin
      ctr_q[wr_idx_i] <= ctr_step(ctr_q[wr_idx_i], wr_up_i);
    end
  end

  // read sees pre-update state on same-entry collision
  assign rd_ctr_o = ctr_q[rd_idx_i];
endmodule

// File: rtl/gh_dir_predictor.sv
module gh_dir_predictor
  import gh_dir_pkg::*;
#(
  parameter int unsigned HIST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pred_req_i,
  output logic              pred_taken_o,
  output logic [HIST_W-1:0] pred_hist_o,
  input  logic              res_valid_i,
  input  logic              res_taken_i,
  input  logic              res_pred_i,
  input  logic [HIST_W-1:0] res_hist_i,
  output logic              flush_o
);
  logic [HIST_W-1:0] hist;
  logic [HIST_W-1:0] restore_val;
  ctr_t              rd_ctr;
  logic              mispredict;

  assign mispredict  = res_valid_i && (res_taken_i != res_pred_i);
  assign restore_val = {res_hist_i[HIST_W-2:0], res_taken_i};

  gh_dir_history #(.HIST_W(HIST_W)) u_hist (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .shift_i       (pred_req_i),
    .shift_bit_i   (pred_taken_o),
    .restore_i     (mispredict),
    .restore_val_i (restore_val),
    .hist_o        (hist)
  );

  gh_dir_table #(.IDX_W(HIST_W)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (hist),
    .rd_ctr_o (rd_ctr),
    .wr_en_i  (res_valid_i),
    .wr_idx_i (res_hist_i),
    .wr_up_i  (res_taken_i)
  );

  assign pred_taken_o = rd_ctr[CTR_W-1];
  assign pred_hist_o  = hist;
  assign flush_o      = mispredict;
endmodule

// File: rtl/gh_dir_predictor_chk.sv
module gh_dir_predictor_chk #(
  parameter int unsigned HIST_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pred_req_i,
  input logic              pred_taken_o,
  input logic [HIST_W-1:0] pred_hist_o,
  input logic              res_valid_i,
  input logic              res_taken_i,
  input logic              res_pred_i,
  input logic [HIST_W-1:0] res_hist_i,
  input logic              flush_o
);
  a_r3_spec_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_req_i && !flush_o) |=>
      pred_hist_o == {$past(pred_hist_o[HIST_W-2:0]), $past(pred_taken_o)});

  a_r4_hist_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pred_req_i && !flush_o) |=> $stable(pred_hist_o));

  a_r7_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> pred_hist_o == {$past(res_hist_i[HIST_W-2:0]), $past(res_taken_i)});

  a_r6_no_flush_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |-> !flush_o);

  a_r6_no_flush_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && (res_taken_i == res_pred_i)) |-> !flush_o);

  a_r9_quiet_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!res_valid_i && !pred_req_i) |=> ($stable(pred_hist_o) && $stable(pred_taken_o)));
endmodule

bind gh_dir_predictor gh_dir_predictor_chk #(.HIST_W(HIST_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pred_req_i   (pred_req_i),
  .pred_taken_o (pred_taken_o),
  .pred_hist_o  (pred_hist_o),
  .res_valid_i  (res_valid_i),
  .res_taken_i  (res_taken_i),
  .res_pred_i   (res_pred_i),
  .res_hist_i   (res_hist_i),
  .flush_o      (flush_o)
);

// File: tb/tb_gh_dir_predictor.sv
module tb_gh_dir_predictor;
  localparam int HIST_W  = 8;
  localparam int ENTRIES = 1 << HIST_W;
  localparam int MASK    = ENTRIES - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic              rst_ni;
  logic              pred_req_i;
  logic              pred_taken_o;
  logic [HIST_W-1:0] pred_hist_o;
  logic              res_valid_i;
  logic              res_taken_i;
  logic              res_pred_i;
  logic [HIST_W-1:0] res_hist_i;
  logic              flush_o;

  gh_dir_predictor #(.HIST_W(HIST_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .pred_req_i(pred_req_i), .pred_taken_o(pred_taken_o), .pred_hist_o(pred_hist_o),
    .res_valid_i(res_valid_i), .res_taken_i(res_taken_i), .res_pred_i(res_pred_i),
    .res_hist_i(res_hist_i), .flush_o(flush_o)
  );

  int    checks = 0;
  int    errors = 0;
  int    m_cnt [ENTRIES];
  int    m_hist = 0;
  string hist_tag = "R1";
  bit    done = 0;
  int    hq [$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle, compare, then advance the reference model
  task automatic step(bit req, bit rv, bit rt, bit rp, int rh, string ptag);
    int exp_pred;
    int exp_flush;
    @(negedge clk);
    pred_req_i  = req;
    res_valid_i = rv;
    res_taken_i = rt;
    res_pred_i  = rp;
    res_hist_i  = HIST_W'(rh);
    #1;
    exp_pred  = (m_cnt[m_hist] >= 2) ? 1 : 0;
    exp_flush = (rv && (rt != rp)) ? 1 : 0;
    chk(ptag, int'(pred_taken_o), exp_pred);
    chk(hist_tag, int'(pred_hist_o), m_hist);
    chk(rv ? "R6" : "R9", int'(flush_o), exp_flush);
    if (rv) begin
      if (rt) m_cnt[rh & MASK] = (m_cnt[rh & MASK] == 3) ? 3 : m_cnt[rh & MASK] + 1;
      else    m_cnt[rh & MASK] = (m_cnt[rh & MASK] == 0) ? 0 : m_cnt[rh & MASK] - 1;
    end
    if (exp_flush != 0) begin
      m_hist = ((rh << 1) | int'(rt)) & MASK;
      hist_tag = "R7";
    end else if (req) begin
      hq.push_back(m_hist);
      m_hist = ((m_hist << 1) | exp_pred) & MASK;
      hist_tag = "R3";
    end else begin
      hist_tag = "R4";
    end
    @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < ENTRIES; e++) m_cnt[e] = 1;
    rst_ni = 1'b0; pred_req_i = 0; res_valid_i = 0; res_taken_i = 0;
    res_pred_i = 0; res_hist_i = '0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1", int'(pred_hist_o), 0);
    chk("R1", int'(pred_taken_o), 0);
    chk("R1", int'(flush_o), 0);
    rst_ni = 1'b1;

    step(0, 0, 0, 0, 0, "R1");
    step(0, 0, 1, 0, 0, "R1");

    // R5: saturate entry 0 up then down
    for (int i = 0; i < 4; i++) step(0, 1, 1, 1, 0, "R5");
    step(0, 0, 0, 0, 0, "R5");                 // counter 3 -> predict 1
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, "R5");
    step(0, 1, 1, 1, 0, "R5");                 // 0 -> 1
    step(0, 0, 0, 0, 0, "R5");                 // still predicts 0

    // R2/R3: speculative shifting
    for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 0, "R2");

    // R7: restore wins over concurrent prediction
    step(1, 1, 1, 0, 'h5A, "R2");
    step(0, 1, 0, 1, 'h33, "R2");
    step(1, 0, 0, 0, 0, "R2");

    // R8: same entry read and trained in one cycle
    step(0, 1, 1, 0, 'h3C, "R2");              // history -> 0x79
    step(0, 1, 0, 1, 'h3C, "R2");              // entry 0x3C back down, history -> 0x78
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 1, 1, m_hist, "R8");
    end

    // R9: resolve inputs toggle with valid low
    for (int i = 0; i < 12; i++)
      step(0, 0, 1'($urandom), 1'($urandom), int'($urandom) & MASK, "R9");

    // mixed random traffic
    hq.delete();
    for (int i = 0; i < 4000; i++) begin
      bit rv;
      int rh;
      rv = ($urandom % 10) < 4;
      rh = (hq.size() > 0 && ($urandom % 4) != 0) ? hq.pop_front() : int'($urandom) & MASK;
      if (hq.size() > 16) void'(hq.pop_front());
      step(1'($urandom), rv, 1'($urandom), 1'($urandom), rh, "R2");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule